// File: doc/BRIEF.md
# Prescaled Auto-Reload Countdown Timer

This block is a private 32-bit countdown timer for one processor core. Software reaches it through four word registers in a 32-byte window: a reload value, the live count, a control word and a sticky interrupt flag. The control word turns the timer on, selects between one-shot and periodic operation, and holds an 8-bit prescaler that stretches each count step over several clock cycles.

Once it is running, the count steps down by one every P+1 clock cycles, where P is the prescaler field. The step taken from a count of 1 is the expiry. It sets the interrupt flag and then either reloads the count from the reload register or parks the count at zero. The interrupt output is a level that follows the flag until software clears it by writing a 1 to the flag register.

The register port is a plain single-cycle select/write strobe. Read data comes back registered on the cycle after the request.

Top module: `prv_timer`

## Requirements
- R1: A synchronous reset sets the reload value, count, control word and interrupt flag to zero, so every register reads 0 and `irq` is low.
- R2: Byte offset 0x0 is the reload value, 0x4 the count, 0x8 the control word and 0xC the flag. An access with address bits 1:0 nonzero, or at offset 0x10 or above, reads 0 and its write changes nothing.
- R3: Control bit 0 enables counting and bits 15:8 hold the prescaler P. The whole control word reads back as written. While the timer is enabled with a nonzero count, the count drops by one every P+1 cycles.
- R4: A write to offset 0x0 stores the value as the reload value and also puts it into the count. If the timer is enabled, the prescaler phase starts again from that write.
- R5: A write to offset 0x4 replaces the count and starts the prescaler phase again.
- R6: When a control write takes the enable bit from 0 to 1 while the count is 0 and the written word sets bit 1, the count takes the reload value.
- R7: The step taken from count 1 sets the flag. With control bit 1 (periodic) set, the count then holds the reload value and keeps running. With bit 1 clear, the count becomes 0 and stops.
- R8: A count of 0 never causes an expiry, even when the timer is enabled in periodic mode with a reload value of 0.
- R9: Reading offset 0x4 returns 0 while the enable bit is clear, even if the count held inside is nonzero.
- R10: The flag reads at bit 0 of offset 0xC and `irq` equals it. The flag is sticky. A write with bit 0 set clears it and a write with bit 0 clear leaves it alone. An expiry in the same cycle as a clear leaves it set.
- R11: `bus_rdata` shows, one cycle after a read request, the register value from before that clock edge, and holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 5 | Byte address inside the 32-byte window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, equal to the sticky flag |

## Verification
The bench uses the default parameters: a 32-bit count, a 5-bit address and an 8-bit prescaler. It programs prescaler values of 0 and 3, so a single step and a stretched step of four cycles are both measured to the exact cycle. Small reload values such as 3 keep each one-shot and periodic expiry within a few cycles. That lets the test land a flag clear on the same edge as an expiry, and catch the decrement and reload edges with back-to-back reads.

// File: rtl/prv_timer_pkg.sv
`timescale 1ns/1ps
package prv_timer_pkg;
  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_ARL_BIT = 1;
  localparam int CTL_PRE_LSB = 8;

  typedef enum logic [2:0] {
    RS_LOAD,
    RS_COUNT,
    RS_CTRL,
    RS_STAT,
    RS_NONE
  } rsel_e;

  typedef struct packed {
    logic load;
    logic count;
    logic ctrl;
    logic stat;
  } wstb_t;
endpackage

// File: rtl/prv_timer_decode.sv
`timescale 1ns/1ps
module prv_timer_decode
  import prv_timer_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  output wstb_t             wstb,
  output rsel_e             rsel,
  output logic              rd_req
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic             aligned;
  logic             in_map;

  assign idx     = bus_addr[ADDR_W-1:2];
  assign aligned = (bus_addr[1:0] == 2'b00);

  // only the lowest four words are mapped
  generate
    if (IDX_W > 2) begin : g_wide
      assign in_map = aligned && (idx[IDX_W-1:2] == '0);
    end else begin : g_narrow
      assign in_map = aligned;
    end
  endgenerate

  always_comb begin
    rsel = RS_NONE;
    if (in_map) begin
      case (idx[1:0])
        2'd0:    rsel = RS_LOAD;
        2'd1:    rsel = RS_COUNT;
        2'd2:    rsel = RS_CTRL;
        default: rsel = RS_STAT;
      endcase
    end
  end

  always_comb begin
    wstb = '0;
    if (bus_sel && bus_wr) begin
      case (rsel)
        RS_LOAD:  wstb.load  = 1'b1;
        RS_COUNT: wstb.count = 1'b1;
        RS_CTRL:  wstb.ctrl  = 1'b1;
        RS_STAT:  wstb.stat  = 1'b1;
        default:  wstb       = '0;
      endcase
    end
  end

  assign rd_req = bus_sel && !bus_wr;
endmodule

// File: rtl/prv_timer_prescale.sv
`timescale 1ns/1ps
module prv_timer_prescale #(
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [PRE_W-1:0] pre_val,
  output logic             tick
);
  logic [PRE_W-1:0] pc_q;

  // >= keeps the step period bounded when P shrinks mid-count
  assign tick = run && (pc_q >= pre_val);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      pc_q <= '0;
    end else if (tick) begin
      pc_q <= '0;
    end else begin
      pc_q <= pc_q + 1'b1;
    end
  end
endmodule

// File: rtl/prv_timer_counter.sv
`timescale 1ns/1ps
module prv_timer_counter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_wr,
  input  logic              cnt_wr,
  input  logic              stat_wr,
  input  logic              en_rise,
  input  logic              arl_new,
  input  logic              arl,
  input  logic              tick,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] load_q,
  output logic [DATA_W-1:0] cnt_q,
  output logic              stat_q,
  output logic              cnt_ovr
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic expire;

  assign cnt_ovr = load_wr || cnt_wr;
  // a software write to the count cancels the step in that cycle
  assign expire  = tick && (cnt_q == ONE) && !cnt_ovr;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= '0;
      cnt_q  <= '0;
      stat_q <= 1'b0;
    end else begin
      if (load_wr) begin
        load_q <= wdata;
      end
      if (cnt_ovr) begin
        cnt_q <= wdata;
      end else if (en_rise && (cnt_q == '0) && arl_new) begin
        cnt_q <= load_q;
      end else if (tick) begin
        if (cnt_q == ONE) begin
          cnt_q <= arl ? load_q : '0;
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
      stat_q <= (stat_q && !(stat_wr && wdata[0])) || expire;
    end
  end
endmodule

// File: rtl/prv_timer.sv
`timescale 1ns/1ps
module prv_timer
  import prv_timer_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int PRE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int PRE_MSB = CTL_PRE_LSB + PRE_W - 1;

  wstb_t             wstb;
  rsel_e             rsel;
  logic              rd_req;
  logic [DATA_W-1:0] ctl_q;
  logic              ctl_en;
  logic              ctl_arl;
  logic              en_rise;
  logic              run;
  logic              restart;
  logic              dec_tick;
  logic [DATA_W-1:0] load_q;
  logic [DATA_W-1:0] cnt_q;
  logic              stat_q;
  logic              cnt_ovr;

  prv_timer_decode #(.ADDR_W(ADDR_W)) u_dec (
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .wstb     (wstb),
    .rsel     (rsel),
    .rd_req   (rd_req)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
    end else if (wstb.ctrl) begin
      ctl_q <= bus_wdata;
    end
  end

  assign ctl_en  = ctl_q[CTL_EN_BIT];
  assign ctl_arl = ctl_q[CTL_ARL_BIT];
  assign en_rise = wstb.ctrl && !ctl_en && bus_wdata[CTL_EN_BIT];
  assign run     = ctl_en && (cnt_q != '0);
  assign restart = cnt_ovr || en_rise;

  prv_timer_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .run     (run),
    .restart (restart),
    .pre_val (ctl_q[PRE_MSB:CTL_PRE_LSB]),
    .tick    (dec_tick)
  );

  prv_timer_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .load_wr (wstb.load),
    .cnt_wr  (wstb.count),
    .stat_wr (wstb.stat),
    .en_rise (en_rise),
    .arl_new (bus_wdata[CTL_ARL_BIT]),
    .arl     (ctl_arl),
    .tick    (dec_tick),
    .wdata   (bus_wdata),
    .load_q  (load_q),
    .cnt_q   (cnt_q),
    .stat_q  (stat_q),
    .cnt_ovr (cnt_ovr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_req) begin
      case (rsel)
        RS_LOAD:  bus_rdata <= load_q;
        RS_COUNT: bus_rdata <= run ? cnt_q : '0;
        RS_CTRL:  bus_rdata <= ctl_q;
        RS_STAT:  bus_rdata <= {{(DATA_W-1){1'b0}}, stat_q};
        default:  bus_rdata <= '0;
      endcase
    end
  end

  assign irq = stat_q;
endmodule

// File: rtl/prv_timer_chk.sv
`timescale 1ns/1ps
module prv_timer_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wr_bit0,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              irq,
  input logic              tick,
  input logic [DATA_W-1:0] cnt,
  input logic              en,
  input logic              arl,
  input logic              cnt_ovr
);
  localparam logic [DATA_W-1:0] ONE = {{(DATA_W-1){1'b0}}, 1'b1};

  logic stat_clr;
  logic cnt_rd;
  logic last_step;

  assign stat_clr  = bus_sel && bus_wr && (bus_addr == ADDR_W'(12)) && wr_bit0;
  assign cnt_rd    = bus_sel && !bus_wr && (bus_addr == ADDR_W'(4));
  assign last_step = tick && (cnt == ONE) && !cnt_ovr;

  AST_DECR_STEP: assert property (@(posedge clk) disable iff (rst)
    (tick && (cnt > ONE) && !cnt_ovr) |=> (cnt == $past(cnt) - ONE)); // R3

  AST_EXPIRE_FLAG: assert property (@(posedge clk) disable iff (rst)
    last_step |=> irq); // R7

  AST_ONESHOT_PARK: assert property (@(posedge clk) disable iff (rst)
    (last_step && !arl) |=> (cnt == '0)); // R7

  AST_ZERO_SILENT: assert property (@(posedge clk) disable iff (rst)
    (cnt == '0) |=> !$rose(irq)); // R8

  AST_OFF_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cnt_rd && !en) |=> (bus_rdata == '0)); // R9

  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (stat_clr && !last_step) |=> !irq); // R10

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_sel && !bus_wr) |=> $stable(bus_rdata)); // R11
endmodule

bind prv_timer prv_timer_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .wr_bit0   (bus_wdata[0]),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .tick      (dec_tick),
  .cnt       (cnt_q),
  .en        (ctl_en),
  .arl       (ctl_arl),
  .cnt_ovr   (cnt_ovr)
);

// File: tb/prv_timer_test.sv
`timescale 1ns/1ps
module prv_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic rd_flag = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  prv_timer uut (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (sel),
    .bus_wr    (wr),
    .bus_addr  (addr),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .irq       (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver tasks are entered on a falling edge
  task automatic bwr(input logic [4:0] a, input logic [31:0] d);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0;
  endtask

  task automatic brd(input logic [4:0] a, input logic [31:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    sel = 1'b1; wr = 1'b0; addr = a;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compares each registered read result against the queue
  always @(posedge clk) rd_flag <= sel && !wr && !rst;

  always @(negedge clk) begin
    if (rd_flag) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R11: actual %h expected <no pending read>", rdata);
      end else begin
        chk(tag_q.pop_front(), rdata, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 reset state
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    brd(5'h00, 32'h0, "R1 load after reset");
    brd(5'h04, 32'h0, "R1 count after reset");
    brd(5'h08, 32'h0, "R1 control after reset");
    brd(5'h0C, 32'h0, "R1 flag after reset");

    // R4 load write; R9 disabled count reads zero
    bwr(5'h00, 32'd5);
    brd(5'h00, 32'd5, "R4 load stored");
    brd(5'h04, 32'd0, "R9 disabled count reads zero");

    // R2 decode edges
    bwr(5'h01, 32'd9);
    bwr(5'h10, 32'd7);
    brd(5'h00, 32'd5, "R2 unaligned write ignored");
    brd(5'h10, 32'd0, "R2 offset 0x10 reads zero");
    brd(5'h1C, 32'd0, "R2 offset 0x1C reads zero");
    brd(5'h02, 32'd0, "R2 unaligned read zero");

    // R3 prescaler P=3: four cycles per step
    bwr(5'h08, 32'h0000_0301);
    brd(5'h08, 32'h0000_0301, "R3 control readback");
    for (int k = 0; k < 3; k++) brd(5'h04, 32'd5, "R3 hold before first step");
    for (int k = 0; k < 4; k++) brd(5'h04, 32'd4, "R3 one step per P+1");
    brd(5'h04, 32'd3, "R3 second step");

    // R5 count write restarts phase
    bwr(5'h04, 32'd20);
    for (int k = 0; k < 4; k++) brd(5'h04, 32'd20, "R5 count replaced");
    brd(5'h04, 32'd19, "R5 step after fresh phase");

    // R4 load write while enabled
    bwr(5'h00, 32'd7);
    brd(5'h00, 32'd7, "R4 load while running");
    for (int k = 0; k < 3; k++) brd(5'h04, 32'd7, "R4 count follows load");
    brd(5'h04, 32'd6, "R4 restart phase");

    // R9 disable
    bwr(5'h08, 32'h0);
    brd(5'h04, 32'd0, "R9 count zero when disabled");

    // R7 one-shot with P=0
    bwr(5'h00, 32'd3);
    bwr(5'h08, 32'h1);
    chk("R7 irq low at start", {31'b0, irq}, 32'h0);
    idle(2);
    chk("R7 irq low before expiry", {31'b0, irq}, 32'h0);
    idle(1);
    chk("R7 irq at expiry", {31'b0, irq}, 32'h1);
    brd(5'h04, 32'd0, "R7 one-shot parks at zero");
    brd(5'h00, 32'd3, "R7 load unchanged");
    idle(5);
    chk("R10 flag sticky", {31'b0, irq}, 32'h1);
    brd(5'h0C, 32'h1, "R10 flag reads one");

    // R10 write-one-to-clear
    bwr(5'h0C, 32'h0);
    chk("R10 zero write keeps flag", {31'b0, irq}, 32'h1);
    bwr(5'h0C, 32'h1);
    chk("R10 one write clears flag", {31'b0, irq}, 32'h0);
    idle(6);
    chk("R8 zero count enabled stays quiet", {31'b0, irq}, 32'h0);

    // R6 enable edge fetches load; R7 periodic
    bwr(5'h08, 32'h0);
    bwr(5'h08, 32'h3);
    brd(5'h04, 32'd3, "R6 count fetched on enable");
    brd(5'h04, 32'd2, "R7 periodic step");
    brd(5'h04, 32'd1, "R7 periodic step");
    brd(5'h04, 32'd3, "R7 periodic reload");
    brd(5'h04, 32'd2, "R7 periodic step");
    brd(5'h04, 32'd1, "R7 periodic step");
    chk("R7 periodic expiry flag", {31'b0, irq}, 32'h1);

    // R10 set wins over clear
    bwr(5'h0C, 32'h1);
    chk("R10 clear between expiries", {31'b0, irq}, 32'h0);
    idle(1);
    bwr(5'h0C, 32'h1);
    chk("R10 set wins over clear", {31'b0, irq}, 32'h1);

    // R8 zero count, zero load, periodic
    bwr(5'h08, 32'h0);
    bwr(5'h0C, 32'h1);
    bwr(5'h00, 32'h0);
    bwr(5'h08, 32'h3);
    idle(8);
    chk("R8 no expiry from zero", {31'b0, irq}, 32'h0);
    brd(5'h04, 32'd0, "R8 count stays zero");
    brd(5'h0C, 32'd0, "R8 flag stays clear");

    // R11 read data held between reads
    bwr(5'h00, 32'h1234);
    brd(5'h00, 32'h1234, "R11 read value");
    idle(3);
    chk("R11 read data held", rdata, 32'h1234);

    // R1 reset while running
    rst = 1'b1;
    idle(1);
    rst = 1'b0;
    chk("R1 irq after mid-run reset", {31'b0, irq}, 32'h0);
    brd(5'h00, 32'h0, "R1 load after mid-run reset");
    brd(5'h04, 32'h0, "R1 count after mid-run reset");
    brd(5'h08, 32'h0, "R1 control after mid-run reset");
    brd(5'h0C, 32'h0, "R1 flag after mid-run reset");
    idle(2);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R11: actual %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule